// File: doc/BRIEF.md
# Triggered Delay Counter with Pulse Outputs

This block is a delay timer that waits for a chosen trigger and then counts clock cycles from zero. A select input picks one of fifteen hardware trigger lines, which act on their rising edge, or a software strobe. Once started, the counter climbs to a programmable modulus and returns to zero. In continuous mode it keeps counting after that. In one-shot mode it halts at zero and waits for the next trigger. While a count is in progress, further triggers have no effect.

A compare against an interrupt-delay value raises a sticky flag. The flag is cleared by a write-one-to-clear strobe. The flag goes to one of two places, chosen by a DMA enable: either an interrupt line gated by an interrupt enable, or a DMA request that holds until it is acknowledged. A set of pulse channels each shape a waveform from two compare values: one raises the output and one lowers it. The lowering value may be smaller than the raising value, and the pulse then spans the wrap. Clearing the global enable stops everything, zeroes the counter and forces the pulses low. All settings arrive as plain input ports.

Top module: `trig_delay_timer`

## Requirements
- R1: `trig_sel` values 0 to 14 select `hw_trig[trig_sel]`, and only a rising edge on that line (low in the previous cycle, high now) starts the counter. The value 15 selects the single-cycle `sw_trig` strobe. Unselected sources have no effect.
- R2: The first clock edge that sees a trigger while idle makes `count` equal 0 with `running` high. Each later edge adds one, and the edge that sees `count == mod_val` returns `count` to 0.
- R3: At the wrap, `running` stays high when `cont_mode` is 1. When `cont_mode` is 0, `running` drops, and `count` stays 0 until the next trigger.
- R4: When `count == irq_dly` while running, `flag` is high from the next edge on. It stays high until an edge sees `flag_clr` high, and a new compare hit at that same edge wins over the clear.
- R5: `irq` is high exactly when `flag` is high, `irq_en` is 1 and `dma_en` is 0, following those inputs in the same cycle.
- R6: A compare hit with `dma_en` at 1 sets `dma_req` from the next edge on, and it stays set until an edge sees `dma_ack` high.
- R7: A trigger that arrives while `running` is high does not restart or change the count.
- R8: For pulse channel i, a hit of `count == rise` while running drives `pulse_out[i]` high from the next edge, and a hit of `count == fall` drives it low. When both values are equal, the output stays low.
- R9: A `fall` value below the `rise` value keeps `pulse_out[i]` high across the wrap, until `count` reaches `fall` in the next round.
- R10: An edge that sees `enable` at 0 sets `count` to 0, clears `running` and drives every `pulse_out` bit low. Triggers are ignored while `enable` is 0.
- R11: After reset, `count`, `running`, `flag`, `irq`, `dma_req` and `pulse_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable |
| trig_sel | input | SEL_W (4) | Trigger source select, 15 = software |
| hw_trig | input | NUM_HW_TRIG (15) | Hardware trigger lines |
| sw_trig | input | 1 | Software trigger strobe |
| cont_mode | input | 1 | 1 = continuous, 0 = one-shot |
| mod_val | input | CNT_W | Count modulus |
| irq_dly | input | CNT_W | Flag compare value |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | Route the flag to DMA instead of the interrupt |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| dma_ack | input | 1 | DMA acknowledge |
| pulse_rise | input | NUM_PULSE*CNT_W | Per-channel rising compare values |
| pulse_fall | input | NUM_PULSE*CNT_W | Per-channel falling compare values |
| count | output | CNT_W | Counter value |
| running | output | 1 | Counter active |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | DMA request |
| pulse_out | output | NUM_PULSE | Pulse outputs |

## Verification
The bench builds the block with an 8-bit counter and two pulse channels. With these values a modulus of a few counts lets every wrap, one-shot stop and continuous restart happen within a handful of cycles. Two channels allow one pulse that stays inside a round and one that spans the wrap to be observed in the same run. The fifteen trigger lines keep their default count, so the software select code 15 and the selection of a mid-range line are both exercised.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    localparam int CNT_W_DEF     = 16;
    localparam int NUM_HW_DEF    = 15;
    localparam int NUM_PULSE_DEF = 2;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } tdt_run_e;

    typedef struct packed {
        logic irq;
        logic dma_set;
    } tdt_route_t;

    function automatic tdt_route_t route_event(input logic flag, input logic hit,
                                               input logic irq_en, input logic dma_en);
        tdt_route_t r;
        r.irq     = flag & irq_en & ~dma_en;
        r.dma_set = hit & dma_en;
        return r;
    endfunction

    function automatic logic pulse_next(input logic cur, input logic hit_rise,
                                        input logic hit_fall);
        logic n;
        n = cur;
        if (hit_fall)      n = 1'b0;
        else if (hit_rise) n = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/tdt_trig_sel.sv
module tdt_trig_sel #(
    parameter int NUM_HW = tdt_pkg::NUM_HW_DEF,
    parameter int SEL_W  = $clog2(NUM_HW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] hw_trig,
    input  logic              sw_trig,
    input  logic [SEL_W-1:0]  sel,
    output logic              trig_evt
);
    localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(NUM_HW);

    logic [NUM_HW-1:0] hw_q;
    logic [NUM_HW-1:0] hw_rise;

    always_ff @(posedge clk) begin
        if (rst) hw_q <= '0;
        else     hw_q <= hw_trig;
    end

    assign hw_rise = hw_trig & ~hw_q;

    always_comb begin
        trig_evt = 1'b0;
        if (sel == SW_CODE) begin
            trig_evt = sw_trig;
        end else begin
            for (int i = 0; i < NUM_HW; i++) begin
                if (sel == SEL_W'(i)) trig_evt = hw_rise[i];
            end
        end
    end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
    parameter int CNT_W = tdt_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             trig_evt,
    input  logic             cont_mode,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    import tdt_pkg::*;

    tdt_run_e         state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_mod;

    assign at_mod = (cnt_q == mod_val);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= RUN_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RUN_IDLE: begin
                    if (trig_evt) begin
                        state_q <= RUN_ACTIVE;
                        cnt_q   <= '0;
                    end
                end
                RUN_ACTIVE: begin
                    if (at_mod) begin
                        cnt_q <= '0;
                        if (!cont_mode) state_q <= RUN_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RUN_IDLE;
            endcase
        end
    end

    assign count   = cnt_q;
    assign running = (state_q == RUN_ACTIVE);
endmodule

// File: rtl/tdt_event_route.sv
module tdt_event_route #(
    parameter int CNT_W = tdt_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] irq_dly,
    input  logic             irq_en,
    input  logic             dma_en,
    input  logic             flag_clr,
    input  logic             dma_ack,
    output logic             flag,
    output logic             irq,
    output logic             dma_req
);
    import tdt_pkg::*;

    logic       hit;
    logic       flag_q;
    logic       dma_q;
    tdt_route_t route;

    assign hit   = enable & running & (count == irq_dly);
    assign route = route_event(flag_q, hit, irq_en, dma_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;

            if (route.dma_set) dma_q <= 1'b1;
            else if (dma_ack)  dma_q <= 1'b0;
        end
    end

    assign flag    = flag_q;
    assign irq     = route.irq;
    assign dma_req = dma_q;
endmodule

// File: rtl/tdt_pulse_gen.sv
module tdt_pulse_gen #(
    parameter int CNT_W     = tdt_pkg::CNT_W_DEF,
    parameter int NUM_PULSE = tdt_pkg::NUM_PULSE_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       running,
    input  logic [CNT_W-1:0]           count,
    input  logic [NUM_PULSE*CNT_W-1:0] pulse_rise,
    input  logic [NUM_PULSE*CNT_W-1:0] pulse_fall,
    output logic [NUM_PULSE-1:0]       pulse_out
);
    import tdt_pkg::*;

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_chan
        logic [CNT_W-1:0] rise_v;
        logic [CNT_W-1:0] fall_v;
        logic             hit_r;
        logic             hit_f;
        logic             po_q;

        assign rise_v = pulse_rise[g*CNT_W +: CNT_W];
        assign fall_v = pulse_fall[g*CNT_W +: CNT_W];
        assign hit_r  = running & (count == rise_v);
        assign hit_f  = running & (count == fall_v);

        always_ff @(posedge clk) begin
            if (rst || !enable) po_q <= 1'b0;
            else                po_q <= pulse_next(po_q, hit_r, hit_f);
        end

        assign pulse_out[g] = po_q;
    end
endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer #(
    parameter int CNT_W       = tdt_pkg::CNT_W_DEF,
    parameter int NUM_HW_TRIG = tdt_pkg::NUM_HW_DEF,
    parameter int NUM_PULSE   = tdt_pkg::NUM_PULSE_DEF,
    parameter int SEL_W       = $clog2(NUM_HW_TRIG + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic [SEL_W-1:0]           trig_sel,
    input  logic [NUM_HW_TRIG-1:0]     hw_trig,
    input  logic                       sw_trig,
    input  logic                       cont_mode,
    input  logic [CNT_W-1:0]           mod_val,
    input  logic [CNT_W-1:0]           irq_dly,
    input  logic                       irq_en,
    input  logic                       dma_en,
    input  logic                       flag_clr,
    input  logic                       dma_ack,
    input  logic [NUM_PULSE*CNT_W-1:0] pulse_rise,
    input  logic [NUM_PULSE*CNT_W-1:0] pulse_fall,
    output logic [CNT_W-1:0]           count,
    output logic                       running,
    output logic                       flag,
    output logic                       irq,
    output logic                       dma_req,
    output logic [NUM_PULSE-1:0]       pulse_out
);
    logic trig_evt;
    logic trig_gated;

    tdt_trig_sel #(.NUM_HW(NUM_HW_TRIG), .SEL_W(SEL_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .hw_trig  (hw_trig),
        .sw_trig  (sw_trig),
        .sel      (trig_sel),
        .trig_evt (trig_evt)
    );

    assign trig_gated = trig_evt & enable;

    tdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .trig_evt  (trig_gated),
        .cont_mode (cont_mode),
        .mod_val   (mod_val),
        .count     (count),
        .running   (running)
    );

    tdt_event_route #(.CNT_W(CNT_W)) u_route (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .running  (running),
        .count    (count),
        .irq_dly  (irq_dly),
        .irq_en   (irq_en),
        .dma_en   (dma_en),
        .flag_clr (flag_clr),
        .dma_ack  (dma_ack),
        .flag     (flag),
        .irq      (irq),
        .dma_req  (dma_req)
    );

    tdt_pulse_gen #(.CNT_W(CNT_W), .NUM_PULSE(NUM_PULSE)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .running    (running),
        .count      (count),
        .pulse_rise (pulse_rise),
        .pulse_fall (pulse_fall),
        .pulse_out  (pulse_out)
    );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
    parameter int CNT_W     = 16,
    parameter int NUM_PULSE = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       enable,
    input logic                       cont_mode,
    input logic [CNT_W-1:0]           mod_val,
    input logic [CNT_W-1:0]           irq_dly,
    input logic                       dma_en,
    input logic                       dma_ack,
    input logic                       flag_clr,
    input logic [NUM_PULSE*CNT_W-1:0] pulse_rise,
    input logic [NUM_PULSE*CNT_W-1:0] pulse_fall,
    input logic [CNT_W-1:0]           count,
    input logic                       running,
    input logic                       flag,
    input logic                       dma_req,
    input logic [NUM_PULSE-1:0]       pulse_out
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (enable && running && count != mod_val) |=> (count == $past(count) + 1'b1)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (enable && running && count == mod_val) |=> (count == '0)); // R2
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (enable && running && !cont_mode && count == mod_val) |=> !running); // R3
    AST_CONT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (enable && running && cont_mode && count == mod_val) |=> running); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (enable && running && count == irq_dly) |=> flag); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag); // R4
    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ack) |=> dma_req); // R6
    AST_DMA_SET: assert property (@(posedge clk) disable iff (rst)
        (enable && running && dma_en && count == irq_dly) |=> dma_req); // R6
    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count == '0 && !running && pulse_out == '0)); // R10

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pchk
        AST_PULSE_RISE: assert property (@(posedge clk) disable iff (rst)
            (enable && running && count == pulse_rise[g*CNT_W +: CNT_W]
             && count != pulse_fall[g*CNT_W +: CNT_W]) |=> pulse_out[g]); // R8
        AST_PULSE_FALL: assert property (@(posedge clk) disable iff (rst)
            (running && count == pulse_fall[g*CNT_W +: CNT_W]) |=> !pulse_out[g]); // R8
    end
endmodule

bind trig_delay_timer tdt_checker #(.CNT_W(CNT_W), .NUM_PULSE(NUM_PULSE)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .cont_mode  (cont_mode),
    .mod_val    (mod_val),
    .irq_dly    (irq_dly),
    .dma_en     (dma_en),
    .dma_ack    (dma_ack),
    .flag_clr   (flag_clr),
    .pulse_rise (pulse_rise),
    .pulse_fall (pulse_fall),
    .count      (count),
    .running    (running),
    .flag       (flag),
    .dma_req    (dma_req),
    .pulse_out  (pulse_out)
);

// File: tb/trig_delay_timer_tb_top.sv
module trig_delay_timer_tb_top;
    localparam int W  = 8;
    localparam int NP = 2;
    localparam int NH = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic [3:0]    trig_sel;
    logic [NH-1:0] hw_trig;
    logic          sw_trig;
    logic          cont_mode;
    logic [W-1:0]  mod_val;
    logic [W-1:0]  irq_dly;
    logic          irq_en;
    logic          dma_en;
    logic          flag_clr;
    logic          dma_ack;
    logic [NP*W-1:0] pulse_rise;
    logic [NP*W-1:0] pulse_fall;
    logic [W-1:0]  count;
    logic          running;
    logic          flag;
    logic          irq;
    logic          dma_req;
    logic [NP-1:0] pulse_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    trig_delay_timer #(.CNT_W(W), .NUM_HW_TRIG(NH), .NUM_PULSE(NP)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .trig_sel(trig_sel),
        .hw_trig(hw_trig), .sw_trig(sw_trig), .cont_mode(cont_mode),
        .mod_val(mod_val), .irq_dly(irq_dly), .irq_en(irq_en), .dma_en(dma_en),
        .flag_clr(flag_clr), .dma_ack(dma_ack), .pulse_rise(pulse_rise),
        .pulse_fall(pulse_fall), .count(count), .running(running), .flag(flag),
        .irq(irq), .dma_req(dma_req), .pulse_out(pulse_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic sw_pulse();
        sw_trig = 1'b1;
        tick(1);
        sw_trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600 && running; i++) tick(1);
    endtask

    task automatic t_reset();
        check("R11", "count", count, 0);
        check("R11", "running", running, 0);
        check("R11", "flag", flag, 0);
        check("R11", "irq", irq, 0);
        check("R11", "dma_req", dma_req, 0);
        check("R11", "pulse_out", pulse_out, 0);
    endtask

    task automatic t_oneshot();
        trig_sel = 4'd15; mod_val = 8'd5; cont_mode = 1'b0;
        sw_pulse();
        check("R2", "start running", running, 1);
        check("R2", "start count", count, 0);
        tick(3);
        check("R2", "count step", count, 3);
        tick(2);
        check("R2", "count at mod", count, 5);
        tick(1);
        check("R2", "wrap count", count, 0);
        check("R3", "one-shot stop", running, 0);
        tick(3);
        check("R3", "stays halted", count, 0);
        check("R8", "equal rise/fall stays low", pulse_out, 0);
    endtask

    task automatic t_flag_irq();
        irq_dly = 8'd3; irq_en = 1'b1; dma_en = 1'b0; mod_val = 8'd6;
        sw_pulse();
        tick(3);
        check("R4", "flag before hit visible", flag, 0);
        tick(1);
        check("R4", "flag set", flag, 1);
        check("R5", "irq on", irq, 1);
        dma_en = 1'b1; #1;
        check("R5", "irq off with dma_en", irq, 0);
        dma_en = 1'b0; irq_en = 1'b0; #1;
        check("R5", "irq off with irq_en low", irq, 0);
        irq_en = 1'b1;
        tick(1);
        check("R4", "flag held", flag, 1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R4", "flag cleared", flag, 0);
        check("R5", "irq cleared", irq, 0);
        wait_idle();
    endtask

    task automatic t_dma();
        dma_en = 1'b1; irq_en = 1'b1; irq_dly = 8'd2; mod_val = 8'd4;
        sw_pulse();
        tick(2);
        check("R6", "dma before hit", dma_req, 0);
        tick(1);
        check("R6", "dma set", dma_req, 1);
        check("R5", "irq masked by dma", irq, 0);
        tick(2);
        check("R6", "dma held", dma_req, 1);
        dma_ack = 1'b1;
        tick(1);
        dma_ack = 1'b0;
        check("R6", "dma acked", dma_req, 0);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        dma_en = 1'b0;
        wait_idle();
    endtask

    task automatic t_hw_trig();
        trig_sel = 4'd3; mod_val = 8'd3; cont_mode = 1'b0;
        hw_trig[5] = 1'b1;
        tick(2);
        check("R1", "unselected line ignored", running, 0);
        sw_pulse();
        tick(1);
        check("R1", "sw strobe ignored on hw select", running, 0);
        hw_trig[3] = 1'b1;
        tick(1);
        check("R1", "selected edge starts", running, 1);
        wait_idle();
        tick(4);
        check("R1", "held level no restart", running, 0);
        hw_trig[3] = 1'b0;
        tick(1);
        hw_trig[3] = 1'b1;
        tick(1);
        check("R1", "second edge starts", running, 1);
        wait_idle();
        hw_trig = '0;
        tick(1);
    endtask

    task automatic t_busy_ignore();
        trig_sel = 4'd15; mod_val = 8'd8; cont_mode = 1'b0;
        sw_pulse();
        tick(3);
        sw_pulse();
        check("R7", "trigger while running ignored", count, 4);
        wait_idle();
    endtask

    task automatic t_cont();
        mod_val = 8'd4; cont_mode = 1'b1;
        sw_pulse();
        tick(4);
        check("R2", "cont at mod", count, 4);
        tick(1);
        check("R2", "cont wrap", count, 0);
        check("R3", "cont keeps running", running, 1);
        tick(1);
        check("R3", "cont recount", count, 1);
        cont_mode = 1'b0;
        wait_idle();
        check("R3", "stop after cont cleared", running, 0);
    endtask

    task automatic t_pulse_disable();
        mod_val = 8'd7; cont_mode = 1'b1;
        pulse_rise = {8'd6, 8'd2};
        pulse_fall = {8'd1, 8'd5};
        sw_pulse();
        check("R8", "pulses low at start", pulse_out, 2'b00);
        tick(2);
        check("R8", "ch0 before rise", pulse_out[0], 0);
        tick(1);
        check("R8", "ch0 high", pulse_out[0], 1);
        tick(2);
        check("R8", "ch0 still high", pulse_out[0], 1);
        tick(1);
        check("R8", "ch0 low", pulse_out[0], 0);
        tick(1);
        check("R9", "ch1 high", pulse_out[1], 1);
        tick(1);
        check("R9", "ch1 high across wrap", pulse_out[1], 1);
        check("R9", "wrapped count", count, 0);
        tick(1);
        check("R9", "ch1 high at 1", pulse_out[1], 1);
        tick(1);
        check("R9", "ch1 low after fall", pulse_out[1], 0);
        tick(5);
        check("R9", "ch1 high again", pulse_out[1], 1);
        enable = 1'b0;
        tick(1);
        check("R10", "count zero", count, 0);
        check("R10", "stopped", running, 0);
        check("R10", "pulses low", pulse_out, 0);
        sw_pulse();
        tick(1);
        check("R10", "trigger ignored while disabled", running, 0);
        enable = 1'b1; cont_mode = 1'b0;
        pulse_rise = '0; pulse_fall = '0;
        tick(1);
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; trig_sel = 4'd15; hw_trig = '0; sw_trig = 1'b0;
        cont_mode = 1'b0; mod_val = '0; irq_dly = 8'hFF; irq_en = 1'b0; dma_en = 1'b0;
        flag_clr = 1'b0; dma_ack = 1'b0; pulse_rise = '0; pulse_fall = '0;
        tick(3);
        rst = 1'b0;
        t_reset();
        enable = 1'b1;
        tick(1);
        t_oneshot();
        t_flag_irq();
        t_dma();
        t_hw_trig();
        t_busy_ignore();
        t_cont();
        t_pulse_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule